// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache placed between a processor port that moves 32-bit words and a slower backing memory. It has a single placement: each block of memory can live in exactly one cache line. A byte address is split into four fields. The lowest two bits pick a byte lane. The next field picks a word inside the line, the field above that picks the line, and the remaining upper bits are kept as the tag. Every line has a tag, an occupied flag and a modified flag.

A hit serves the access at once. A read returns the word one cycle after it is accepted. A write merges only the enabled bytes and marks the line modified. On a miss the controller first checks the line it must replace. If that line is occupied and modified, all of its words are copied back to memory. The new line is then fetched word by word, its tag is recorded, and the access that was held completes as an ordinary hit. While a copy-back or a fetch is in progress, the processor port stays stalled.

The controller has three states. `ST_IDLE` looks up the tag and serves hits. `ST_WBACK` streams the victim line out to memory. `ST_FILL` streams the new line in. The transitions are as follows:
- `ST_IDLE`→`ST_WBACK` on a miss whose victim is occupied and modified.
- `ST_IDLE`→`ST_FILL` on a miss whose victim is empty or clean.
- `ST_WBACK`→`ST_FILL` when memory acknowledges the last victim word.
- `ST_FILL`→`ST_IDLE` when memory acknowledges the last fetched word. This is the cycle in which the tag is stored.

Top module: `dm_wb_cache`

## Requirements
- R1: Reset clears every occupied and modified flag. After reset no memory request and no response is raised, and the first access to any line misses without a copy-back.
- R2: Address bits [1:0] select only the byte lane; they do not change which word is read. With OFF_W = log2(BLOCK_WORDS) and IDX_W = log2(NUM_BLOCKS), bits [OFF_W+1:2] give the word, bits [OFF_W+IDX_W+1:OFF_W+2] give the line, and the upper bits give the tag. Every memory request carries the address {tag, line, word, 2'b00}.
- R3: A read hit is accepted in the same cycle as it is presented. It raises cpu_resp_valid in the next cycle with the stored word, and it causes no memory traffic.
- R4: A write hit updates byte lane b (bits [8b+7:8b]) only when cpu_req_be[b] is 1. It marks the line modified and causes no memory traffic.
- R5: A miss whose victim is empty or clean issues exactly BLOCK_WORDS memory reads of the new line, in ascending word order starting at word 0, with no memory write.
- R6: A miss whose victim is occupied and modified first issues BLOCK_WORDS memory writes, in ascending word order. They go to the victim's own address, carry the victim's current contents, and all come before the first read of the fill.
- R7: A write miss completes as a write hit after the fill. The merged word is readable afterwards, and the line is modified, so a later eviction copies it back.
- R8: cpu_req_ready is low in every cycle in which a memory request is raised.
- R9: A line that has been filled and never written is clean. Evicting it causes no copy-back.
- R10: Once raised, a memory request keeps its valid, direction, address and write data unchanged until the cycle in which mem_ack is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle (idle and hit) |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_be | input | 4 | Byte lane enables for writes |
| cpu_req_wdata | input | 32 | Write data |
| cpu_resp_valid | output | 1 | Read data valid |
| cpu_resp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory word request raised |
| mem_req_write | output | 1 | 1 = copy-back write, 0 = fill read |
| mem_req_addr | output | 32 | Word-aligned byte address of the request |
| mem_req_wdata | output | 32 | Copy-back data |
| mem_ack | input | 1 | Memory accepts the current word this cycle |
| mem_rdata | input | 32 | Fill data, valid while mem_ack is high on a read |

## Verification
The assertions rely on two conditions at the processor port. A stalled request keeps its address, direction, data and byte enables unchanged until it is accepted. mem_ack is only raised while a memory request is pending. The bench meets the first condition by changing the request only after it sees cpu_req_ready high and one accepting edge has passed. Its memory model raises mem_ack only in reply to a raised request, after a varying delay of zero to two cycles, which also exercises the hold rule. The bench keeps a model of the tags and the memory image. Its sweeps are ordered so that every line passes through the empty, clean and modified victim cases.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } dmc_state_e;

    localparam int WORD_BYTES = 4;
    localparam int WORD_BITS  = 8 * WORD_BYTES;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int NUM_BLOCKS = 16,
    parameter int IDX_W      = 4,
    parameter int TAG_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             set_dirty,
    input  logic             fill_done,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             valid_o,
    output logic             dirty_o,
    output logic [TAG_W-1:0] tag_o
);
    logic [NUM_BLOCKS-1:0] valid_q;
    logic [NUM_BLOCKS-1:0] dirty_q;
    logic [TAG_W-1:0]      tag_q [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_done) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (set_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[idx] <= fill_tag;
        end
    end

    assign valid_o = valid_q[idx];
    assign dirty_o = dirty_q[idx];
    assign tag_o   = tag_q[idx];

    // R9: a freshly filled line is occupied, clean and carries the new tag
    p_fill_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]
                       && tag_q[$past(idx)] == $past(fill_tag)));

    // R4: a write hit leaves its line marked modified
    p_dirty_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_dirty |=> dirty_q[$past(idx)]);

    // R4, R7: a single update source per cycle
    p_one_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_dirty && fill_done));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [3:0]    wbe,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (wbe[b]) begin
                    mem_q[waddr][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int TAG_W = 24,
    parameter int IDX_W = 4,
    parameter int OFF_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    input  logic                   cpu_write,
    input  logic [3:0]             cpu_be,
    input  logic [31:0]            cpu_wdata,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic [IDX_W-1:0]       req_idx,
    input  logic [OFF_W-1:0]       req_off,
    input  logic                   vic_valid,
    input  logic                   vic_dirty,
    input  logic [TAG_W-1:0]       vic_tag,
    input  logic [31:0]            rd_word,
    input  logic                   mem_ack,
    input  logic [31:0]            mem_rdata,
    output logic                   cpu_ready,
    output logic                   resp_valid,
    output logic [31:0]            resp_rdata,
    output logic                   mem_valid,
    output logic                   mem_write,
    output logic [31:0]            mem_addr,
    output logic [31:0]            mem_wdata,
    output logic                   ds_we,
    output logic [IDX_W+OFF_W-1:0] ds_waddr,
    output logic [3:0]             ds_be,
    output logic [31:0]            ds_wdata,
    output logic [IDX_W+OFF_W-1:0] ds_raddr,
    output logic                   ts_set_dirty,
    output logic                   ts_fill_done
);
    dmc_state_e       state_q, state_d;
    logic [OFF_W-1:0] cnt_q, cnt_d;
    logic             hit;
    logic             victim_dirty;
    logic             last_word;

    assign hit          = vic_valid && (vic_tag == req_tag);
    assign victim_dirty = vic_valid && vic_dirty;
    assign last_word    = &cnt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (cpu_valid && !hit) begin
                    state_d = victim_dirty ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    cnt_d = cnt_q + 1'b1;
                    if (last_word) state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    cnt_d = cnt_q + 1'b1;
                    if (last_word) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_ready    = 1'b0;
        mem_valid    = 1'b0;
        mem_write    = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        ds_we        = 1'b0;
        ds_waddr     = {req_idx, req_off};
        ds_be        = cpu_be;
        ds_wdata     = cpu_wdata;
        ds_raddr     = {req_idx, req_off};
        ts_set_dirty = 1'b0;
        ts_fill_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = hit;
                if (cpu_valid && hit && cpu_write) begin
                    ds_we        = 1'b1;
                    ts_set_dirty = 1'b1;
                end
            end
            ST_WBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {vic_tag, req_idx, cnt_q, 2'b00};
                ds_raddr  = {req_idx, cnt_q};
                mem_wdata = rd_word;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_tag, req_idx, cnt_q, 2'b00};
                if (mem_ack) begin
                    ds_we        = 1'b1;
                    ds_waddr     = {req_idx, cnt_q};
                    ds_be        = 4'hF;
                    ds_wdata     = mem_rdata;
                    ts_fill_done = last_word;
                end
            end
            default: ;
        endcase
    end

    // Read response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= cpu_valid && cpu_ready && !cpu_write;
            if (cpu_valid && cpu_ready && !cpu_write) begin
                resp_rdata <= rd_word;
            end
        end
    end

    // R8: no processor acceptance while memory traffic is in flight
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !cpu_ready);

    // R10: a pending memory request holds until acknowledged
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr)
                                     && $stable(mem_write) && $stable(mem_wdata)));

    // R3: a response follows only an accepted read
    p_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(cpu_valid && cpu_ready && !cpu_write));

    // R2: memory requests are word aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R5: a fill straight from idle only replaces a victim that is not modified
    p_clean_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && $past(state_q) == ST_IDLE) |-> $past(!(vic_valid && vic_dirty)));
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
    parameter int NUM_BLOCKS  = 16,
    parameter int BLOCK_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic        cpu_req_write,
    input  logic [31:0] cpu_req_addr,
    input  logic [3:0]  cpu_req_be,
    input  logic [31:0] cpu_req_wdata,
    output logic        cpu_resp_valid,
    output logic [31:0] cpu_resp_rdata,
    output logic        mem_req_valid,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int IDX_W = $clog2(NUM_BLOCKS);
    localparam int OFF_W = $clog2(BLOCK_WORDS);
    localparam int TAG_W = 30 - IDX_W - OFF_W;
    localparam int AW    = IDX_W + OFF_W;
    localparam int DEPTH = NUM_BLOCKS * BLOCK_WORDS;

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic [1:0]       byte_sel_unused;

    assign byte_sel_unused = cpu_req_addr[1:0];
    assign req_off = cpu_req_addr[OFF_W+1:2];
    assign req_idx = cpu_req_addr[AW+1:OFF_W+2];
    assign req_tag = cpu_req_addr[31:AW+2];

    logic             vic_valid, vic_dirty;
    logic [TAG_W-1:0] vic_tag;
    logic             ts_set_dirty, ts_fill_done;
    logic             ds_we;
    logic [AW-1:0]    ds_waddr, ds_raddr;
    logic [3:0]       ds_be;
    logic [31:0]      ds_wdata, rd_word;

    dmc_tag_store #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .set_dirty(ts_set_dirty),
        .fill_done(ts_fill_done),
        .fill_tag (req_tag),
        .valid_o  (vic_valid),
        .dirty_o  (vic_dirty),
        .tag_o    (vic_tag)
    );

    dmc_data_store #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_data (
        .clk  (clk),
        .we   (ds_we),
        .waddr(ds_waddr),
        .wbe  (ds_be),
        .wdata(ds_wdata),
        .raddr(ds_raddr),
        .rdata(rd_word)
    );

    dmc_ctrl #(
        .TAG_W(TAG_W),
        .IDX_W(IDX_W),
        .OFF_W(OFF_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_valid   (cpu_req_valid),
        .cpu_write   (cpu_req_write),
        .cpu_be      (cpu_req_be),
        .cpu_wdata   (cpu_req_wdata),
        .req_tag     (req_tag),
        .req_idx     (req_idx),
        .req_off     (req_off),
        .vic_valid   (vic_valid),
        .vic_dirty   (vic_dirty),
        .vic_tag     (vic_tag),
        .rd_word     (rd_word),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .cpu_ready   (cpu_req_ready),
        .resp_valid  (cpu_resp_valid),
        .resp_rdata  (cpu_resp_rdata),
        .mem_valid   (mem_req_valid),
        .mem_write   (mem_req_write),
        .mem_addr    (mem_req_addr),
        .mem_wdata   (mem_req_wdata),
        .ds_we       (ds_we),
        .ds_waddr    (ds_waddr),
        .ds_be       (ds_be),
        .ds_wdata    (ds_wdata),
        .ds_raddr    (ds_raddr),
        .ts_set_dirty(ts_set_dirty),
        .ts_fill_done(ts_fill_done)
    );

    // R1: after reset no response is pending
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_resp_valid) |-> $past(cpu_req_valid));
endmodule

// File: tb/sim_dm_wb_cache.sv
module sim_dm_wb_cache;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int WPB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [3:0]  cpu_req_be = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    dm_wb_cache #(.NUM_BLOCKS(NB), .BLOCK_WORDS(WPB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_be(cpu_req_be), .cpu_req_wdata(cpu_req_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int r8_bad   = 0;
    int r10_bad  = 0;

    logic [31:0] gold [int unsigned];
    logic [31:0] bmem [int unsigned];

    bit          mv [NB];
    bit          md [NB];
    int          mt [NB];

    logic [31:0] lg_addr [32];
    bit          lg_wr   [32];
    logic [31:0] lg_data [32];
    int          log_n = 0;
    int          tot = 0;
    int          wcnt = 0;
    bit          pend = 1'b0;
    logic [31:0] p_addr, p_data;
    bit          p_wr;

    function automatic logic [31:0] init_val(input int unsigned wa);
        return (wa * 32'h0100_0193) ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] get_gold(input int unsigned wa);
        return gold.exists(wa) ? gold[wa] : init_val(wa);
    endfunction

    function automatic logic [31:0] get_bmem(input int unsigned wa);
        return bmem.exists(wa) ? bmem[wa] : init_val(wa);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] mk_addr(input int t, input int ix, input int w);
        return (32'(t) << 7) | (32'(ix) << 5) | (32'(w) << 2);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Backing memory model, acting away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wcnt = 0;
            pend = 1'b0;
        end else begin
            if (pend && (!mem_req_valid || mem_req_addr != p_addr || mem_req_write != p_wr
                         || (p_wr && mem_req_wdata != p_data))) r10_bad++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req_valid) begin
                if (wcnt < (tot % 3)) begin
                    wcnt++;
                end else begin
                    wcnt = 0;
                    mem_ack = 1'b1;
                    tot++;
                    if (log_n < 32) begin
                        lg_addr[log_n] = mem_req_addr;
                        lg_wr[log_n]   = mem_req_write;
                        lg_data[log_n] = mem_req_wdata;
                    end
                    log_n++;
                    if (mem_req_write) bmem[mem_req_addr >> 2] = mem_req_wdata;
                    else mem_rdata = get_bmem(mem_req_addr >> 2);
                end
            end
            pend   = mem_req_valid && !mem_ack;
            p_addr = mem_req_addr;
            p_wr   = mem_req_write;
            p_data = mem_req_wdata;
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                finish_run();
            end
        end
    end

    task automatic access(input bit wr, input int t, input int ix, input int w,
                          input logic [3:0] be, input logic [31:0] wd,
                          input logic [1:0] bsel, input string dlabel);
        logic [31:0]  addr = mk_addr(t, ix, w) | 32'(bsel);
        int unsigned  wa = addr >> 2;
        bit           miss = !(mv[ix] && mt[ix] == t);
        bit           dv = miss && mv[ix] && md[ix];
        int           vt = mt[ix];
        int           exp_n = dv ? 2*WPB : (miss ? WPB : 0);
        string        lenlab;
        logic [31:0]  exp_rd = get_gold(wa);
        int           k = 0;
        if (dv) lenlab = "R6";
        else if (miss && !mv[ix]) lenlab = "R1 R5";
        else if (miss) lenlab = "R5 R9";
        else lenlab = wr ? "R4" : "R3";
        @(negedge clk);
        log_n = 0;
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = addr;
        cpu_req_be    = be;
        cpu_req_wdata = wd;
        #1;
        while (!cpu_req_ready) begin
            @(negedge clk);
            if (mem_req_valid && cpu_req_ready) r8_bad++;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (!wr) begin
            check(cpu_resp_valid, dlabel, 32'(cpu_resp_valid), 32'd1);
            check(cpu_resp_rdata == exp_rd, dlabel, cpu_resp_rdata, exp_rd);
        end
        check(log_n == exp_n, lenlab, 32'(log_n), 32'(exp_n));
        if (dv) begin
            for (int w2 = 0; w2 < WPB; w2++) begin
                logic [31:0] ea = mk_addr(vt, ix, w2);
                if (k < log_n) begin
                    check(lg_wr[k] && lg_addr[k] == ea, "R6 R2", lg_addr[k], ea);
                    check(lg_data[k] == get_gold(ea >> 2), "R6", lg_data[k], get_gold(ea >> 2));
                end
                k++;
            end
        end
        if (miss) begin
            for (int w2 = 0; w2 < WPB; w2++) begin
                logic [31:0] ea = mk_addr(t, ix, w2);
                if (k < log_n) check(!lg_wr[k] && lg_addr[k] == ea, "R5 R2", lg_addr[k], ea);
                k++;
            end
        end
        if (wr) gold[wa] = merge(get_gold(wa), wd, be);
        md[ix] = miss ? wr : (md[ix] | wr);
        mv[ix] = 1'b1;
        mt[ix] = t;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(!mem_req_valid, "R1", 32'(mem_req_valid), 32'd0);
        check(!cpu_resp_valid, "R1", 32'(cpu_resp_valid), 32'd0);

        // Write every word of tag 0 with cycling byte enables (R1, R5, R4)
        for (int ix = 0; ix < NB; ix++)
            for (int w = 0; w < WPB; w++)
                access(1'b1, 0, ix, w, 4'(((ix*WPB + w) % 15) + 1),
                       32'hC0DE_0000 + 32'(ix*256 + w*17), 2'd0, "R4");
        // Read back with varying byte-lane bits (R3, R4, R2)
        for (int ix = 0; ix < NB; ix++)
            for (int w = 0; w < WPB; w++)
                access(1'b0, 0, ix, w, 4'h0, '0, 2'(w), "R3 R4 R2");
        // Dirty victims copied back (R6)
        for (int ix = 0; ix < NB; ix++) access(1'b0, 1, ix, 3, 4'h0, '0, 2'd0, "R6");
        // Clean victims dropped; copied data readable again (R9, R6)
        for (int ix = 0; ix < NB; ix++) access(1'b0, 0, ix, ix, 4'h0, '0, 2'd1, "R9 R6");
        // Write miss completes as a write, then evicted with merged data (R7)
        for (int ix = 0; ix < NB; ix++) begin
            access(1'b1, 2, ix, 5, 4'b0101, 32'hFACE_B00C ^ 32'(ix), 2'd0, "R7");
            access(1'b0, 2, ix, 5, 4'h0, '0, 2'd0, "R7");
            access(1'b0, 3, ix, 5, 4'h0, '0, 2'd0, "R7");
            access(1'b0, 2, ix, 5, 4'h0, '0, 2'd2, "R7");
        end
        // Mixed sweep over tags, lines and words
        for (int t = 0; t < 4; t++)
            for (int ix = 0; ix < NB; ix++)
                for (int w = 0; w < WPB; w += 3) begin
                    bit wr = ((t + ix + w) % 2) == 1;
                    access(wr, t, ix, w, 4'(((t*7 + w) % 15) + 1),
                           32'h1234_0000 ^ 32'(t*4096 + ix*64 + w), 2'(t), wr ? "R4 R7" : "R3");
                end

        check(r8_bad == 0, "R8", 32'(r8_bad), 32'd0);
        check(r10_bad == 0, "R10", 32'(r10_bad), 32'd0);
        finish_run();
    end
endmodule